// File: doc/BRIEF.md
# Asynchronous Serial Port with CTS Gating and Address-Bit Framing

This block is a full-duplex asynchronous serial port for one byte-wide link. A byte handed over on the transmit stream is framed as a low start bit, eight data bits (least significant first) and an optional ninth bit. It closes with one or two high stop bits. The ninth bit is either a parity bit or, in multiprocessor mode, an address marker supplied with the byte. The receiver oversamples its line sixteen times per bit, samples each bit at its centre, and presents each byte on a receive stream. A three-bit status word goes with the byte: the last address-marker value, a new-frame flag and a parity-error flag.

All bit timing comes from `baud_tick`, a one-cycle pulse at sixteen times the bit rate. Control register 0 holds eight fields. From bit 7 down to bit 0 they are: transmit enable, receive enable, CTS gating enable, parity enable, parity select, send break, two-stop-bit select and loopback. Control register 1 bit 0 selects multiprocessor mode. Software configures the port while both enables are 0. While either enable is set, writes can only change the enables.

Both data interfaces are valid/ready. On transmit, `tx_ready` is high only when the transmitter is enabled, idle and not held off by CTS. A byte moves on the cycle where `tx_valid` and `tx_ready` are both high. On receive, `rx_valid` holds a byte until the cycle where `rx_ready` is high. The receiver cannot be stalled by the line, so a byte that arrives before the previous one was taken replaces it. Taking a byte clears its status bits.

Top module: `sercom_mp`

## Requirements
- R1: After reset, both control registers read 0, `txd` is 1, `tx_ready` is 0, `rx_valid` is 0 and `rx_stat` is 0.
- R2: `cfg_sel`=0 writes control register 0 (bit7 transmit enable, bit6 receive enable, bit5 CTS gating, bit4 parity enable, bit3 parity select, bit2 break, bit1 two stop bits, bit0 loopback) and `cfg_sel`=1 writes bit 0 of control register 1 (multiprocessor mode). While bit7 or bit6 of register 0 is 1, a write to register 0 changes only bits 7:6, and a write to register 1 is ignored.
- R3: `tx_ready` is 1 exactly when transmit enable is 1, no frame is in progress, and either CTS gating is 0 or `cts_n` is 0. When CTS gating is 0, `cts_n` has no effect.
- R4: An accepted byte appears on `txd` from the next cycle as a 0 start bit, data bit 0 through bit 7, the optional ninth bit, and a 1 stop bit. A second 1 stop bit follows when register 0 bit1 is 1. Each bit lasts exactly 16 `baud_tick` pulses counted after the accepting edge. `txd` idles at 1.
- R5: With parity enabled and multiprocessor mode off, the ninth bit is the XOR of the data bits XOR the parity-select bit (0 gives even, 1 gives odd).
- R6: In multiprocessor mode the ninth bit is `tx_mpbit` and no parity bit is sent. On receive, `rx_stat[0]` is the received ninth bit and `rx_stat[1]` (new frame) is 1 when that bit is 1.
- R7: While the break bit is 1, `txd` is 0.
- R8: With loopback set, the receiver samples the port's own transmit line and ignores `rxd`.
- R9: The receiver presents the byte on `rx_data` with `rx_valid` held high until a cycle with `rx_ready` high. A byte completed before then replaces the held one.
- R10: `rx_stat[2]` is 1 when parity is enabled, multiprocessor mode is off and the received ninth bit does not match the parity computed from the data. After a cycle with `rx_valid` and `rx_ready` both high, and no new byte in that cycle, `rx_valid` and all of `rx_stat` are 0.
- R11: While receive enable is 0, no byte is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_wr | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0 selects control register 0, 1 selects control register 1 |
| cfg_wdata | input | 8 | Control write data |
| cfg_q | output | 8 | Control register 0 contents |
| mp_q | output | 1 | Multiprocessor-mode bit of control register 1 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter takes the offered byte |
| tx_data | input | 8 | Transmit byte |
| tx_mpbit | input | 1 | Ninth bit to send in multiprocessor mode |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the byte and clears status |
| rx_data | output | 8 | Received byte |
| rx_stat | output | 3 | {parity error, new frame, last ninth bit} |
| cts_n | input | 1 | Clear-to-send, active low |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The parity-error flag is the hardest state to reach. The port's own transmitter always produces correct parity, so loopback can never raise it. The stimulus therefore switches loopback off and drives `rxd` directly, one bit per 16 counted baud ticks, with a deliberately wrong ninth bit. It then takes the byte and confirms that the flag is gone. The CTS hold-off and the write-while-enabled rule are reached by changing `cts_n` and writing the control register while a byte is offered or the port is running. A cycle-by-cycle model of the transmit line flags any change in the ready or the frame timing.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  typedef struct packed {
    logic ten;
    logic ren;
    logic ctse;
    logic pen;
    logic psel;
    logic sbrk;
    logic stop2;
    logic lben;
  } ctl0_t;

endpackage

// File: rtl/sercom_regs.sv
module sercom_regs
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] wdata,
  output ctl0_t      ctl,
  output logic       mp_en
);

  logic running;
  assign running = ctl.ten | ctl.ren;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      mp_en <= 1'b0;
    end else if (wr) begin
      if (running) begin
        // only the enables may change while the port runs
        if (!sel) begin
          ctl.ten <= wdata[7];
          ctl.ren <= wdata[6];
        end
      end else if (sel) begin
        mp_en <= wdata[0];
      end else begin
        ctl <= ctl0_t'(wdata);
      end
    end
  end

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic          pen,
  input  logic          psel,
  input  logic          stop2,
  input  logic          sbrk,
  input  logic          mp_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_mp,
  output logic          txd
);

  localparam int FW = DW + 4;
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [FW-1:0] sh, frame;
  logic [LW-1:0] left, nbits;
  logic [CW-1:0] cnt;
  logic          busy;

  assign busy     = (left != '0);
  assign in_ready = go && !busy;

  always_comb begin
    frame           = '1;
    frame[0]        = 1'b0;
    frame[DW:1]     = in_data;
    nbits           = LW'(DW + 2);
    if (mp_en) begin
      frame[DW+1] = in_mp;
      nbits       = nbits + 1'b1;
    end else if (pen) begin
      frame[DW+1] = (^in_data) ^ psel;
      nbits       = nbits + 1'b1;
    end
    if (stop2) nbits = nbits + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
    end else if (in_valid && in_ready) begin
      sh   <= frame;
      left <= nbits;
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign txd = sbrk ? 1'b0 : (busy ? sh[0] : 1'b1);

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          line,
  input  logic          pen,
  input  logic          psel,
  input  logic          mp_en,
  output logic          done,
  output logic [DW-1:0] dout,
  output logic          mpb,
  output logic          perr
);

  localparam int CW = $clog2(OVS);
  localparam int XW = $clog2(DW + 3);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [XW-1:0] DWI  = XW'(DW);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_t;

  rx_st_t        st;
  logic [CW-1:0] cnt;
  logic [XW-1:0] idx;
  logic [DW-1:0] dreg;
  logic          xb;
  logic          extra;

  assign extra = mp_en | pen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= '0;
      dreg <= '0;
      xb   <= 1'b0;
      done <= 1'b0;
      dout <= '0;
      mpb  <= 1'b0;
      perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
      end else if (tick) begin
        unique case (st)
          S_IDLE: if (!line) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
          S_START: begin
            if (cnt == HALF) begin
              cnt <= '0;
              idx <= '0;
              st  <= line ? S_IDLE : S_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BITS: begin
            if (cnt == LAST) begin
              cnt <= '0;
              idx <= idx + 1'b1;
              if (idx < DWI) begin
                dreg[idx[IW-1:0]] <= line;
              end else if (extra && idx == DWI) begin
                xb <= line;
              end else begin
                st   <= S_IDLE;
                done <= 1'b1;
                dout <= dreg;
                mpb  <= mp_en & xb;
                perr <= pen & ~mp_en & (xb ^ (^dreg) ^ psel);
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sercom_mp.sv
module sercom_mp
  import sercom_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_q,
  output logic          mp_q,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_mpbit,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic [2:0]    rx_stat,
  input  logic          cts_n,
  input  logic          rxd,
  output logic          txd
);

  ctl0_t         ctl;
  logic          mp_en;
  logic          tx_go;
  logic          rx_line;
  logic          rx_done;
  logic [DW-1:0] rx_byte;
  logic          rx_mpb, rx_perr;
  logic [SYNC-1:0] sy;

  sercom_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .ctl(ctl), .mp_en(mp_en)
  );

  assign cfg_q = ctl;
  assign mp_q  = mp_en;
  assign tx_go = ctl.ten && (!ctl.ctse || !cts_n);

  sercom_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .go(tx_go),
    .pen(ctl.pen), .psel(ctl.psel), .stop2(ctl.stop2), .sbrk(ctl.sbrk),
    .mp_en(mp_en), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .in_mp(tx_mpbit), .txd(txd)
  );

  genvar g;
  for (g = 0; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy[g] <= 1'b1;
      else        sy[g] <= (g == 0) ? rxd : sy[(g == 0) ? 0 : g - 1];
    end
  end

  assign rx_line = ctl.lben ? txd : sy[SYNC-1];

  sercom_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctl.ren),
    .line(rx_line), .pen(ctl.pen), .psel(ctl.psel), .mp_en(mp_en),
    .done(rx_done), .dout(rx_byte), .mpb(rx_mpb), .perr(rx_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_stat  <= '0;
    end else if (rx_done) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
      rx_stat  <= {rx_perr, rx_mpb, rx_mpb};
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
      rx_stat  <= '0;
    end
  end

endmodule

// File: rtl/sercom_mp_chk.sv
module sercom_mp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_q,
  input logic       cfg_wr,
  input logic       cfg_sel,
  input logic       tx_ready,
  input logic       cts_n,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [2:0] rx_stat,
  input logic       rx_done
);

  // R3
  no_ready_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> cfg_q[7]);

  // R3
  cts_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5] && cts_n) |-> !tx_ready);

  // R7
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2] |-> !txd);

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !cfg_q[2]) |-> txd);

  // R2
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && (cfg_q[7] || cfg_q[6])) |=> (cfg_q[5:0] == $past(cfg_q[5:0])));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !rx_done) |=> (!rx_valid && rx_stat == 3'b000));

  // R6
  newframe_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stat[1] |-> rx_stat[0]);

endmodule

bind sercom_mp sercom_mp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .tx_ready(tx_ready), .cts_n(cts_n), .txd(txd), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_stat(rx_stat), .rx_done(rx_done)
);

// File: tb/sercom_mp_test.sv
`timescale 1ns/1ps
module sercom_mp_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_q;
  logic       mp_q;
  logic       tx_valid = 1'b0, tx_ready, tx_mpbit = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] rx_stat;
  logic       cts_n = 1'b0, rxd = 1'b1, txd;

  always #2 clk = ~clk;

  sercom_mp uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .mp_q(mp_q),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_mpbit(tx_mpbit), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_stat(rx_stat), .cts_n(cts_n), .rxd(rxd), .txd(txd)
  );

  int errs = 0, checks = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // baud tick: one pulse every 3 clocks, driven after the edge
  always begin
    @(posedge clk); #1;
    cyc++;
    baud_tick = (cyc % 3 == 0);
  end

  // behavioural model of control register and transmit line
  logic [7:0] m_ctl;
  bit         m_mp, m_rdy;
  int         mq[$];
  int         mcnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0; m_mp = 0; mq.delete(); mcnt = 0;
    end else begin
      m_rdy = m_ctl[7] && mq.size() == 0 && (!m_ctl[5] || !cts_n);
      if (tx_valid && m_rdy) begin
        mq.push_back(0);
        for (int i = 0; i < 8; i++) mq.push_back(tx_data[i]);
        if (m_mp) mq.push_back(tx_mpbit);
        else if (m_ctl[4]) mq.push_back((^tx_data) ^ m_ctl[3]);
        mq.push_back(1);
        if (m_ctl[1]) mq.push_back(1);
        mcnt = 0;
      end else if (mq.size() > 0 && baud_tick) begin
        if (mcnt == 15) begin mcnt = 0; void'(mq.pop_front()); end
        else mcnt++;
      end
      if (cfg_wr) begin
        if (m_ctl[7] || m_ctl[6]) begin
          if (!cfg_sel) m_ctl[7:6] = cfg_wdata[7:6];
        end else if (cfg_sel) m_mp = cfg_wdata[0];
        else m_ctl = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit et, er;
      et = m_ctl[2] ? 1'b0 : (mq.size() > 0 ? mq[0][0] : 1'b1);
      er = m_ctl[7] && mq.size() == 0 && (!m_ctl[5] || !cts_n);
      chk(txd === et, "R4", "txd bit", txd, et);
      chk(tx_ready === er, "R3", "tx_ready", tx_ready, er);
      chk(cfg_q === m_ctl, "R2", "ctl0", cfg_q, m_ctl);
      chk(mp_q === m_mp, "R2", "ctl1", mp_q, m_mp);
    end
  end

  task automatic wr(bit sel, logic [7:0] v);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic reconf(logic [7:0] v);
    wr(0, 8'h00);
    wr(0, v);
  endtask

  task automatic send(logic [7:0] d, bit mp);
    @(posedge clk); #1;
    tx_valid = 1; tx_data = d; tx_mpbit = mp;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #1;
    tx_valid = 0;
    while (mq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic take();
    @(posedge clk); #1; rx_ready = 1;
    @(posedge clk); #1; rx_ready = 0;
    @(negedge clk);
    chk(rx_valid === 0, "R10", "rx_valid after take", rx_valid, 0);
    chk(rx_stat === 3'b000, "R10", "status after take", rx_stat, 0);
  endtask

  task automatic rx_bit(bit b);
    int n;
    rxd = b;
    n = 0;
    while (n < 16) begin
      @(posedge clk);
      if (baud_tick) n++;
    end
    #1;
  endtask

  task automatic rx_frame(logic [7:0] d, bit ninth);
    rx_bit(0);
    for (int i = 0; i < 8; i++) rx_bit(d[i]);
    rx_bit(ninth);
    rx_bit(1);
    repeat (60) @(posedge clk);
    #1;
  endtask

  task automatic expect_rx(logic [7:0] d, logic [2:0] st, string tag);
    @(negedge clk);
    chk(rx_valid === 1, tag, "rx_valid", rx_valid, 1);
    chk(rx_data === d, tag, "rx_data", rx_data, d);
    chk(rx_stat === st, tag, "rx_stat", rx_stat, st);
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cfg_q === 8'h00, "R1", "ctl0", cfg_q, 0);
    chk(mp_q === 0, "R1", "ctl1", mp_q, 0);
    chk(txd === 1, "R1", "txd", txd, 1);
    chk(tx_ready === 0, "R1", "tx_ready", tx_ready, 0);
    chk(rx_valid === 0 && rx_stat === 0, "R1", "rx side", {rx_valid, rx_stat}, 0);
    #1 rst_n = 1;
    cmp_on = 1;

    // R8: loopback, external line held low must be ignored
    rxd = 0;
    wr(0, 8'hC1);
    send(8'hA5, 0);
    expect_rx(8'hA5, 3'b000, "R8");
    take();
    // R2: locked fields while enabled
    wr(0, 8'hF6);
    @(negedge clk);
    chk(cfg_q === 8'hC1, "R2", "locked write", cfg_q, 8'hC1);
    wr(1, 8'h01);
    @(negedge clk);
    chk(mp_q === 0, "R2", "ctl1 locked", mp_q, 0);

    // R5 even parity with two stop bits, then odd
    reconf(8'hD3);
    send(8'h03, 0);
    expect_rx(8'h03, 3'b000, "R5");
    take();
    reconf(8'hD9);
    send(8'h07, 0);
    expect_rx(8'h07, 3'b000, "R5");
    take();

    // R9 overwrite of an untaken byte
    send(8'h11, 0);
    send(8'h22, 0);
    expect_rx(8'h22, 3'b000, "R9");
    take();

    // R10 parity error from the external line
    reconf(8'hD0);
    rxd = 1;
    repeat (10) @(posedge clk);
    rx_frame(8'h55, 1);
    expect_rx(8'h55, 3'b100, "R10");
    take();
    rx_frame(8'h54, 1);
    expect_rx(8'h54, 3'b000, "R10");
    take();

    // R6 multiprocessor ninth bit
    wr(0, 8'h00);
    wr(0, 8'h01);
    wr(1, 8'h01);
    wr(0, 8'hC1);
    send(8'h12, 1);
    expect_rx(8'h12, 3'b011, "R6");
    take();
    send(8'h34, 0);
    expect_rx(8'h34, 3'b000, "R6");
    take();
    wr(0, 8'h00);
    wr(1, 8'h00);

    // R3 CTS hold-off, then release
    wr(0, 8'hA0);
    cts_n = 1;
    @(posedge clk); #1;
    tx_valid = 1; tx_data = 8'h0F;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(tx_ready === 0 && txd === 1, "R3", "cts held", {tx_ready, txd}, 2'b01);
    #1 tx_valid = 0;
    cts_n = 0;
    send(8'h0F, 0);
    // R3 CTS ignored when gating is off
    reconf(8'h80);
    cts_n = 1;
    @(negedge clk);
    chk(tx_ready === 1, "R3", "cts ignored", tx_ready, 1);
    send(8'h3C, 0);
    cts_n = 0;

    // R11 receiver disabled in loopback
    reconf(8'h81);
    send(8'h5A, 0);
    @(negedge clk);
    chk(rx_valid === 0, "R11", "no byte while off", rx_valid, 0);

    // R7 break
    reconf(8'h84);
    repeat (20) @(negedge clk);
    chk(txd === 0, "R7", "break line", txd, 0);
    wr(0, 8'h04);
    wr(0, 8'h00);
    repeat (5) @(negedge clk);
    chk(txd === 1, "R7", "break released", txd, 1);

    summary();
  end

endmodule